// File: doc/BRIEF.md
# PWM Event-Driven Output Shaper with Continuous Override

This block sits between a time-base counter and two PWM output pins, A and B. On each counter tick it receives up to four match events: counter zero, counter period, compare-A match while counting up, and compare-B match while counting up. Each output has its own action word. The word gives every event a 2-bit action code that keeps the output, drives it low, drives it high or toggles it. When several events arrive on the same tick, one fixed priority picks the single action that is applied.

Above the event logic sits a continuous software override for each output. Software writes the override code into a shadow copy. The shadow copy moves into the active override at a reload point chosen by a separate field: counter zero, counter period, either of the two, or the next counter tick. While an override is active it sets the pin level. The event-driven waveform keeps running underneath, and the pin returns to that waveform when the override is released.

Configuration is written through a simple write-only port. Each register word sits at a fixed offset.

Top module: `pwm_evt_shaper`

## Requirements
- R1: After reset both outputs are low. Every action code is 00, so events leave the outputs low, and no override is active.
- R2: The action word for output A sits at offset 0x16 and the one for output B at 0x18. Within each word, the zero event uses bits [1:0], the period event [3:2], compare-A up [5:4] and compare-B up [9:8]. Code 00 keeps the output, 01 drives it low, 10 drives it high and 11 toggles it. The new level appears after the clock edge of the tick that carries the event.
- R3: Events have no effect on any clock edge where tick_en is low.
- R4: When several events fall on one tick, only the highest-priority event whose code is non-zero acts. Priority runs period, then compare B, then compare A, then zero.
- R5: The override word at offset 0x1C holds output A's code in bits [1:0] and output B's in bits [3:2]. Code 01 forces the pin low and 10 forces it high. Codes 00 and 11 release the pin to the event waveform. An active override wins over every event action.
- R6: Bits [7:6] of the word at offset 0x1A select the reload point: 00 at a zero tick, 01 at a period tick, 10 at either, 11 at the next tick. A reload point counts only when tick_en is high.
- R7: A written override code changes no pin until its reload point occurs.
- R8: The event waveform keeps updating while a pin is overridden. After release the pin shows the waveform's current level.
- R9: A write to any other offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter tick qualifier |
| ev_zero | input | 1 | Counter reached zero |
| ev_period | input | 1 | Counter reached period |
| ev_cmpa_up | input | 1 | Compare A matched while counting up |
| ev_cmpb_up | input | 1 | Compare B matched while counting up |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word offset |
| cfg_wdata | input | DATA_W | Configuration write data |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |

## Verification
A corrupted waveform bit or action field shows at a pin on the first tick whose event uses that field. If the pin is overridden at that moment, the error appears at the release instead. A wrong shadow or active override code, or a reload taken at the wrong event, moves a pin one tick early or late compared with the reload point. Because of this the bench compares both pins against a reference model on every cycle. A long mixed random run with frequent overlapping events and writes exposes priority and reload errors within a few ticks.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

   localparam int unsigned NUM_OUT = 2;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } act_code_e;

   typedef enum logic [1:0] {
      RLD_ZERO   = 2'b00,
      RLD_PERIOD = 2'b01,
      RLD_EITHER = 2'b10,
      RLD_NOW    = 2'b11
   } reload_sel_e;

   typedef struct packed {
      act_code_e on_cmpb;
      act_code_e on_cmpa;
      act_code_e on_period;
      act_code_e on_zero;
   } evt_actions_t;

   typedef struct packed {
      logic zero;
      logic period;
      logic cmpa;
      logic cmpb;
   } evt_set_t;

endpackage

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
   import pwm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16,
   parameter logic [ADDR_W-1:0] OFS_ACT_A  = 'h16,
   parameter logic [ADDR_W-1:0] OFS_ACT_B  = 'h18,
   parameter logic [ADDR_W-1:0] OFS_RELOAD = 'h1A,
   parameter logic [ADDR_W-1:0] OFS_FORCE  = 'h1C
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [ADDR_W-1:0]      cfg_addr,
   input  logic [DATA_W-1:0]      cfg_wdata,
   output evt_actions_t [NUM_OUT-1:0] act_cfg,
   output reload_sel_e            reload_sel,
   output logic [2*NUM_OUT-1:0]   force_shadow
);

   localparam int unsigned USED_W = 10;

   if (DATA_W < USED_W) begin : g_width_chk
      $error("pwm_evt_regs: DATA_W must be at least 10");
   end

   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata[DATA_W-1:USED_W] ^ cfg_wdata[7] ^ cfg_wdata[6];

   function automatic evt_actions_t unpack_actions(input logic [DATA_W-1:0] d);
      evt_actions_t r;
      r.on_zero   = act_code_e'(d[1:0]);
      r.on_period = act_code_e'(d[3:2]);
      r.on_cmpa   = act_code_e'(d[5:4]);
      r.on_cmpb   = act_code_e'(d[9:8]);
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg      <= '0;
         reload_sel   <= RLD_ZERO;
         force_shadow <= '0;
      end else if (cfg_we) begin
         unique case (cfg_addr)
            OFS_ACT_A:  act_cfg[0]   <= unpack_actions(cfg_wdata);
            OFS_ACT_B:  act_cfg[1]   <= unpack_actions(cfg_wdata);
            OFS_RELOAD: reload_sel   <= reload_sel_e'(cfg_wdata[7:6]);
            OFS_FORCE:  force_shadow <= cfg_wdata[2*NUM_OUT-1:0];
            default: ;
         endcase
      end
   end

   // R9: a write outside the map leaves every register unchanged
   assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr != OFS_ACT_A && cfg_addr != OFS_ACT_B &&
       cfg_addr != OFS_RELOAD && cfg_addr != OFS_FORCE)
      |=> ($stable(act_cfg) && $stable(reload_sel) && $stable(force_shadow)));

endmodule

// File: rtl/pwm_evt_resolve.sv
module pwm_evt_resolve
   import pwm_evt_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  evt_set_t     ev,
   input  evt_actions_t cfg,
   output logic         wave
);

   act_code_e chosen;
   logic      wave_q;

   // later assignments win: zero < cmpa < cmpb < period
   always_comb begin
      chosen = ACT_KEEP;
      if (ev.zero   && cfg.on_zero   != ACT_KEEP) chosen = cfg.on_zero;
      if (ev.cmpa   && cfg.on_cmpa   != ACT_KEEP) chosen = cfg.on_cmpa;
      if (ev.cmpb   && cfg.on_cmpb   != ACT_KEEP) chosen = cfg.on_cmpb;
      if (ev.period && cfg.on_period != ACT_KEEP) chosen = cfg.on_period;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (tick_en) begin
         unique case (chosen)
            ACT_LOW:    wave_q <= 1'b0;
            ACT_HIGH:   wave_q <= 1'b1;
            ACT_TOGGLE: wave_q <= ~wave_q;
            default:    wave_q <= wave_q;
         endcase
      end
   end

   assign wave = wave_q;

   assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(wave_q));

   assert_no_event_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && ev == '0) |=> $stable(wave_q));

   assert_period_low_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && ev.period && cfg.on_period == ACT_LOW) |=> !wave_q);

   assert_period_high_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && ev.period && cfg.on_period == ACT_HIGH) |=> wave_q);

endmodule

// File: rtl/pwm_evt_force.sv
module pwm_evt_force
   import pwm_evt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 ev_zero,
   input  logic                 ev_period,
   input  reload_sel_e          reload_sel,
   input  logic [2*NUM_OUT-1:0] shadow,
   output logic [2*NUM_OUT-1:0] active
);

   logic load;

   always_comb begin
      unique case (reload_sel)
         RLD_ZERO:   load = tick_en && ev_zero;
         RLD_PERIOD: load = tick_en && ev_period;
         RLD_EITHER: load = tick_en && (ev_zero || ev_period);
         default:    load = tick_en;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active <= '0;
      else if (load) active <= shadow;
   end

   // R7: the active override moves only at a reload point
   assert_active_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(active));

   // R6: immediate mode takes the shadow on the next tick
   assert_now_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && reload_sel == RLD_NOW) |=> active == $past(shadow));

   // R6: a period-only reload point ignores zero ticks
   assert_period_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_sel == RLD_PERIOD && !ev_period) |=> $stable(active));

endmodule

// File: rtl/pwm_evt_shaper.sv
module pwm_evt_shaper
   import pwm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              ev_zero,
   input  logic              ev_period,
   input  logic              ev_cmpa_up,
   input  logic              ev_cmpb_up,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              pwm_a,
   output logic              pwm_b
);

   if (ADDR_W < 5) begin : g_addr_chk
      $error("pwm_evt_shaper: ADDR_W must reach offset 0x1C");
   end

   evt_actions_t [NUM_OUT-1:0] act_cfg;
   reload_sel_e                reload_sel;
   logic [2*NUM_OUT-1:0]       force_shadow;
   logic [2*NUM_OUT-1:0]       force_active;
   logic [NUM_OUT-1:0]         wave;
   logic [NUM_OUT-1:0]         pin;
   evt_set_t                   ev;

   assign ev.zero   = ev_zero;
   assign ev.period = ev_period;
   assign ev.cmpa   = ev_cmpa_up;
   assign ev.cmpb   = ev_cmpb_up;

   pwm_evt_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .act_cfg      (act_cfg),
      .reload_sel   (reload_sel),
      .force_shadow (force_shadow)
   );

   pwm_evt_force u_force (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .ev_zero    (ev_zero),
      .ev_period  (ev_period),
      .reload_sel (reload_sel),
      .shadow     (force_shadow),
      .active     (force_active)
   );

   for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_ch
      pwm_evt_resolve u_resolve (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_en (tick_en),
         .ev      (ev),
         .cfg     (act_cfg[ch]),
         .wave    (wave[ch])
      );

      always_comb begin
         unique case (act_code_e'(force_active[2*ch+1:2*ch]))
            ACT_LOW:  pin[ch] = 1'b0;
            ACT_HIGH: pin[ch] = 1'b1;
            default:  pin[ch] = wave[ch];
         endcase
      end

      // R8: a released pin follows the event waveform
      assert_release_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (force_active[2*ch+1] == force_active[2*ch]) |-> pin[ch] == wave[ch]);
   end

   assign pwm_a = pin[0];
   assign pwm_b = pin[1];

endmodule

// File: tb/pwm_evt_shaper_bench.sv
module pwm_evt_shaper_bench;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0, ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa_up = 1'b0, ev_cmpb_up = 1'b0;
   logic cfg_we = 1'b0;
   logic [ADDR_W-1:0] cfg_addr = '0;
   logic [DATA_W-1:0] cfg_wdata = '0;
   logic pwm_a, pwm_b;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [9:0] m_act [2];
   logic [1:0] m_mode;
   logic [3:0] m_shadow, m_active;
   logic [1:0] m_wave;

   always #10 clk = ~clk;

   pwm_evt_shaper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pwm_evt_shaper (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ev_zero(ev_zero),
      .ev_period(ev_period), .ev_cmpa_up(ev_cmpa_up), .ev_cmpb_up(ev_cmpb_up),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pwm_a(pwm_a), .pwm_b(pwm_b));

   function automatic logic apply_code(input logic [1:0] c, input logic cur);
      case (c)
         2'b01:   return 1'b0;
         2'b10:   return 1'b1;
         2'b11:   return ~cur;
         default: return cur;
      endcase
   endfunction

   // priority: period > cmpB > cmpA > zero, first non-zero code
   function automatic logic next_wave(input logic [9:0] w, input logic cur,
                                      input logic z, input logic p, input logic a, input logic b);
      if (p && w[3:2] != 2'b00) return apply_code(w[3:2], cur);
      if (b && w[9:8] != 2'b00) return apply_code(w[9:8], cur);
      if (a && w[5:4] != 2'b00) return apply_code(w[5:4], cur);
      if (z && w[1:0] != 2'b00) return apply_code(w[1:0], cur);
      return cur;
   endfunction

   function automatic logic pin_model(input logic [1:0] f, input logic w);
      if (f == 2'b01) return 1'b0;
      if (f == 2'b10) return 1'b1;
      return w;
   endfunction

   task automatic check_bit(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      m_act[0] = '0; m_act[1] = '0; m_mode = '0;
      m_shadow = '0; m_active = '0; m_wave = '0;
   endtask

   task automatic model_edge();
      logic ld;
      logic [1:0] nw;
      ld = 1'b0;
      if (tick_en) begin
         case (m_mode)
            2'b00: ld = ev_zero;
            2'b01: ld = ev_period;
            2'b10: ld = ev_zero | ev_period;
            default: ld = 1'b1;
         endcase
      end
      nw = m_wave;
      if (tick_en) begin
         for (int ch = 0; ch < 2; ch++)
            nw[ch] = next_wave(m_act[ch], m_wave[ch], ev_zero, ev_period, ev_cmpa_up, ev_cmpb_up);
      end
      if (ld) m_active = m_shadow;
      m_wave = nw;
      if (cfg_we) begin
         case (cfg_addr)
            8'h16: m_act[0] = {cfg_wdata[9:8], cfg_wdata[7:6], cfg_wdata[5:0]};
            8'h18: m_act[1] = {cfg_wdata[9:8], cfg_wdata[7:6], cfg_wdata[5:0]};
            8'h1A: m_mode = cfg_wdata[7:6];
            8'h1C: m_shadow = cfg_wdata[3:0];
            default: ;
         endcase
      end
   endtask

   // one clock: model follows the edge, outputs sampled at the falling edge
   task automatic cycle(input string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cyc++;
      check_bit(req, "pwm_a", pwm_a, pin_model(m_active[1:0], m_wave[0]));
      check_bit(req, "pwm_b", pwm_b, pin_model(m_active[3:2], m_wave[1]));
      tick_en = 1'b0; ev_zero = 1'b0; ev_period = 1'b0; ev_cmpa_up = 1'b0; ev_cmpb_up = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input string req);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      cycle(req);
   endtask

   task automatic tk(input logic en, input logic z, input logic p, input logic a,
                     input logic b, input string req);
      tick_en = en; ev_zero = z; ev_period = p; ev_cmpa_up = a; ev_cmpb_up = b;
      cycle(req);
   endtask

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(negedge clk);
      check_bit("R1", "pwm_a in reset", pwm_a, 1'b0);
      check_bit("R1", "pwm_b in reset", pwm_b, 1'b0);
      rst_n = 1'b1;
      // R1: actions all 00 -> every event leaves pins low
      tk(1, 1, 1, 1, 1, "R1");
      check_bit("R1", "pwm_a after events", pwm_a, 1'b0);

      // R2: A zero->high, cmpA->low ; B zero->toggle
      wr(8'h16, 16'h0012, "R2");
      wr(8'h18, 16'h0003, "R2");
      tk(1, 1, 0, 0, 0, "R2");
      check_bit("R2", "pwm_a high on zero", pwm_a, 1'b1);
      check_bit("R2", "pwm_b toggled", pwm_b, 1'b1);
      tk(1, 0, 0, 1, 0, "R2");
      check_bit("R2", "pwm_a low on cmpA", pwm_a, 1'b0);
      tk(1, 1, 0, 0, 0, "R2");
      check_bit("R2", "pwm_b toggled back", pwm_b, 1'b0);

      // R3: events without tick enable do nothing
      tk(0, 1, 1, 1, 1, "R3");
      check_bit("R3", "pwm_a held", pwm_a, 1'b1);

      // R4: zero=low, cmpA=high, cmpB=toggle, period=keep -> cmpB wins
      wr(8'h16, 16'h0321, "R4");
      tk(1, 1, 1, 1, 1, "R4");
      check_bit("R4", "cmpB toggle wins", pwm_a, 1'b0);
      wr(8'h16, 16'h0325, "R4");
      tk(1, 1, 1, 1, 1, "R4");
      check_bit("R4", "period low wins", pwm_a, 1'b0);
      tk(1, 1, 0, 1, 0, "R4");
      check_bit("R4", "cmpA beats zero", pwm_a, 1'b1);

      // R9: unmapped offsets change nothing
      wr(8'h10, 16'hFFFF, "R9");
      wr(8'h17, 16'hFFFF, "R9");
      tk(1, 1, 1, 1, 1, "R9");

      // R5/R6/R7: zero reload mode, force A low, B high
      wr(8'h1A, 16'h0000, "R6");
      wr(8'h1C, 16'h0009, "R7");
      tk(1, 0, 1, 0, 0, "R7");
      check_bit("R7", "pwm_b not yet forced", pwm_b, 1'b0);
      tk(1, 1, 0, 0, 0, "R6");
      check_bit("R5", "pwm_b forced high", pwm_b, 1'b1);
      check_bit("R5", "pwm_a forced low", pwm_a, 1'b0);
      // R8: waveform runs beneath the override
      wr(8'h16, 16'h0002, "R8");
      tk(1, 1, 0, 0, 0, "R8");
      check_bit("R8", "pwm_a still forced", pwm_a, 1'b0);
      // R6: period reload, release with code 11
      wr(8'h1A, 16'h0040, "R6");
      wr(8'h1C, 16'h000F, "R6");
      tk(1, 1, 0, 0, 0, "R6");
      check_bit("R6", "zero ignored in period mode", pwm_a, 1'b0);
      tk(1, 0, 1, 0, 0, "R6");
      check_bit("R8", "pwm_a back to waveform", pwm_a, 1'b1);
      // R6: either mode and immediate mode
      wr(8'h1A, 16'h0080, "R6");
      wr(8'h1C, 16'h0001, "R6");
      tk(1, 0, 1, 0, 0, "R6");
      check_bit("R6", "either mode at period", pwm_a, 1'b0);
      wr(8'h1A, 16'h00C0, "R6");
      wr(8'h1C, 16'h0000, "R6");
      tk(0, 0, 0, 0, 0, "R6");
      check_bit("R6", "immediate waits for tick", pwm_a, 1'b0);
      tk(1, 0, 0, 0, 0, "R6");
      check_bit("R6", "immediate release", pwm_a, 1'b1);

      // random mix against the model (R2, R4, R5, R6)
      for (int i = 0; i < 4000; i++) begin
         tick_en    = ($urandom % 4) != 0;
         ev_zero    = ($urandom % 4) == 0;
         ev_period  = ($urandom % 4) == 0;
         ev_cmpa_up = ($urandom % 3) == 0;
         ev_cmpb_up = ($urandom % 3) == 0;
         if (($urandom % 8) == 0) begin
            cfg_we = 1'b1;
            case ($urandom % 5)
               0: cfg_addr = 8'h16;
               1: cfg_addr = 8'h18;
               2: cfg_addr = 8'h1A;
               3: cfg_addr = 8'h1C;
               default: cfg_addr = 8'h1E;
            endcase
            cfg_wdata = 16'($urandom);
         end
         cycle("R4");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule